// File: doc/BRIEF.md
# Quadrature Encoder Decoder with Phase-Error Detection

This block turns a pair of quadrature encoder signals, A and B, into a one-cycle count strobe and a direction level for a counter that sits next to it. Each input first passes through a two-flop synchronizer and then through a glitch filter. The filter's stability length is set at run time, and a length of zero turns it off. A resolution select picks one of three decoding modes. In single-rate mode only A edges taken while B is low are counted. In double-rate mode every A edge is counted. In quad-rate mode every edge of either signal is counted.

Valid quadrature never moves both signals at once. The block treats a change on one filtered input that lands in the same cycle as a change on the other, or within a parameterised number of cycles after it, as an encoding fault. A fault produces a one-cycle event pulse, which a snapshot unit can use as a trigger. It also sets a sticky flag, which stays set until software pulses the clear input. The edge that completes a fault is never counted.

Top module: `quad_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high and on the first cycle after it, `count_en`, `dir`, `err_event` and `err_flag` are all 0.
- R2: With `mult` = 2'b00 (single rate), only an A edge taken while filtered B is 0 produces a count. A rising edge counts up and a falling edge counts down. A edges taken while B is 1 produce no count, and neither do B edges.
- R3: With `mult` = 2'b01 (double rate), every A edge produces a count. The count is up when the new A level differs from B and down when it equals B. B edges produce no count.
- R4: With `mult` = 2'b10 or 2'b11 (quad rate), every edge on A or B produces a count. The up direction follows the {A,B} sequence 00, 10, 11, 01, and the reverse sequence counts down.
- R5: Each counted edge gives exactly one cycle of `count_en` = 1. `dir` (1 = up) is updated only together with `count_en` and holds its value otherwise.
- R6: A fault is an edge on one filtered input that arrives in the same cycle as an edge on the other, or within `ERR_WIN` cycles after it. A fault gives a one-cycle `err_event` and no count for the faulting edge. Edges spaced further apart than this raise no fault.
- R7: `err_flag` rises together with `err_event` and stays at 1 until `err_clr` is sampled high. When a new fault and `err_clr` fall in the same cycle, the flag stays set.
- R8: With `filt_len` = 0, a change on an input reaches `count_en` on the fourth rising edge after it is applied. With `filt_len` = N > 0, a pulse that lasts fewer than N cycles is discarded and gives neither a count nor a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | Encoder phase A, single-ended level |
| in_b | input | 1 | Encoder phase B, single-ended level |
| mult | input | 2 | Resolution: 00 single, 01 double, 1x quad |
| filt_len | input | FILT_W | Glitch filter stability length in cycles, 0 = bypass |
| err_clr | input | 1 | Pulse to clear the sticky fault flag |
| count_en | output | 1 | One-cycle count strobe |
| dir | output | 1 | Count direction, 1 = up |
| err_event | output | 1 | One-cycle encoding fault pulse |
| err_flag | output | 1 | Sticky encoding fault flag |

## Verification
The embedded properties assume that `mult` and `filt_len` stay constant while an encoder step is working its way through the synchronizer and filter, and the stimulus changes them only after the inputs have been idle for longer than the filter and window spans combined. The random walks advance one Gray step at a time and hold each level well beyond the filter length and the fault window. As a result, faults and discarded pulses come only from the directed cases that are built to produce them. One directed case lines up the clear pulse with the cycle in which a fault registers, so that the priority between setting and clearing the flag is exercised.

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int FILT_W  = 4,
  parameter int ERR_WIN = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_a,
  input  logic              in_b,
  input  logic [1:0]        mult,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              err_clr,
  output logic              count_en,
  output logic              dir,
  output logic              err_event,
  output logic              err_flag
);
  localparam int AW = $clog2(ERR_WIN + 1) + 1;
  localparam logic [AW-1:0] WIN = AW'(ERR_WIN);

  logic [1:0] s1, s2, s2d, f, fp;
  logic [FILT_W-1:0] st [2];
  logic [AW-1:0] age_a, age_b;
  logic ea, eb, err, step, up;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; s2d <= '0; f <= '0; fp <= '0;
      for (int i = 0; i < 2; i++) st[i] <= '0;
    end else begin
      s1  <= {in_b, in_a};
      s2  <= s1;
      s2d <= s2;
      fp  <= f;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] != s2d[i]) st[i] <= '0;
        else if (st[i] != '1) st[i] <= st[i] + 1'b1;
        if (filt_len == '0 ||
            (s2[i] == s2d[i] && ({1'b0, st[i]} + 1'b1) >= {1'b0, filt_len}))
          f[i] <= s2[i];
      end
    end
  end

  assign ea  = f[0] ^ fp[0];
  assign eb  = f[1] ^ fp[1];
  assign err = (ea && eb) || (ea && age_b < WIN) || (eb && age_a < WIN);

  always_comb begin
    case (mult)
      2'b00:   begin step = ea && !f[1]; up = f[0]; end
      2'b01:   begin step = ea;          up = f[0] ^ f[1]; end
      default: begin step = ea || eb;    up = ea ? (f[0] ^ f[1]) : ~(f[0] ^ f[1]); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      age_a <= WIN; age_b <= WIN;
      count_en <= 1'b0; dir <= 1'b0; err_event <= 1'b0; err_flag <= 1'b0;
    end else begin
      age_a <= ea ? '0 : (age_a < WIN ? age_a + 1'b1 : age_a);
      age_b <= eb ? '0 : (age_b < WIN ? age_b + 1'b1 : age_b);
      count_en  <= step && !err;
      if (step && !err) dir <= up;
      err_event <= err;
      err_flag  <= err || (err_flag && !err_clr);
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !count_en && !err_event && !err_flag); // R1
  AST_CNT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst) count_en |-> $past(ea || eb)); // R5
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst) !count_en |-> $stable(dir)); // R5
  AST_NO_CNT_ON_FAULT: assert property (@(posedge clk) disable iff (rst) err_event |-> !count_en); // R6
  AST_FLAG_WITH_EVENT: assert property (@(posedge clk) disable iff (rst) $rose(err_flag) |-> err_event); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (err_flag && !err_clr) |=> err_flag); // R7
  AST_X1_B_LOW: assert property (@(posedge clk) disable iff (rst) (count_en && $past(mult) == 2'b00) |-> !$past(f[1])); // R2
endmodule

// File: tb/quad_decoder_tb.sv
`timescale 1ns/1ps
module quad_decoder_tb;
  logic clk = 0, rst = 1, in_a = 0, in_b = 0, err_clr = 0;
  logic [1:0] mult = 2'b00;
  logic [3:0] filt_len = '0;
  logic count_en, dir, err_event, err_flag;
  int errors = 0, checks = 0, pos = 0, npulse = 0, nerr = 0;
  bit done = 0;

  quad_decoder #(.FILT_W(4), .ERR_WIN(1)) u_dut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .mult(mult),
    .filt_len(filt_len), .err_clr(err_clr), .count_en(count_en),
    .dir(dir), .err_event(err_event), .err_flag(err_flag));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (!rst) begin
    if (count_en) begin npulse++; pos += dir ? 1 : -1; end
    if (err_event) nerr++;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dlt(int m, bit oa, bit ob, bit na, bit nb);
    bit xa, xb;
    xa = oa ^ na; xb = ob ^ nb;
    if (m == 0) return (xa && !nb) ? (na ? 1 : -1) : 0;
    if (m == 1) return xa ? ((na ^ nb) ? 1 : -1) : 0;
    if (xa) return (na ^ nb) ? 1 : -1;
    if (xb) return (na ^ nb) ? -1 : 1;
    return 0;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic walk(int m, string req, int steps);
    int p0, n0, e0, ep, en, idx;
    bit na, nb;
    p0 = pos; n0 = npulse; e0 = nerr; ep = 0; en = 0;
    idx = in_a ? (in_b ? 2 : 1) : (in_b ? 3 : 0);
    mult = 2'(m);
    for (int k = 0; k < steps; k++) begin
      idx = ($urandom % 2) ? (idx + 1) % 4 : (idx + 3) % 4;
      na = (idx == 1 || idx == 2); nb = (idx == 2 || idx == 3);
      ep += dlt(m, in_a, in_b, na, nb);
      en += (dlt(m, in_a, in_b, na, nb) != 0);
      in_a = na; in_b = nb;
      idle(24);
    end
    chk(pos - p0 == ep, req, "net count", pos - p0, ep);
    chk(npulse - n0 == en, req, "pulse total", npulse - n0, en);
    chk(nerr == e0, "R6", "no fault on clean walk", nerr - e0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    idle(3);
    chk(count_en == 0 && dir == 0, "R1", "outputs in reset", {count_en, dir}, 0);
    chk(err_event == 0 && err_flag == 0, "R1", "fault outputs in reset", {err_event, err_flag}, 0);
    @(negedge clk) rst = 0;
    chk(count_en == 0 && err_flag == 0, "R1", "after release", {count_en, err_flag}, 0);

    // R8 bypass latency, single rate rising A with B low
    mult = 2'b00;
    in_a = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(count_en == 0, "R8", "count_en before 4th edge", count_en, 0);
    @(negedge clk);
    chk(count_en == 1 && dir == 1, "R8", "count_en at 4th edge (R2 up)", {count_en, dir}, 3);
    @(negedge clk);
    chk(count_en == 0, "R5", "strobe lasts one cycle", count_en, 0);
    in_a = 0; idle(10);
    chk(dir == 0, "R2", "A falls with B low counts down", dir, 0);

    for (int r = 0; r < 3; r++) begin
      filt_len = 4'(r * 3);
      walk(0, "R2", 40);
      walk(1, "R3", 40);
      walk(2 + r % 2, "R4", 40);
    end

    // R8 glitch rejection
    filt_len = 4'd4; mult = 2'b10; in_a = 0; in_b = 0; idle(20);
    begin
      int n0, e0;
      n0 = npulse; e0 = nerr;
      in_a = 1; idle(2); in_a = 0; idle(20);
      chk(npulse == n0, "R8", "short pulse gives no count", npulse - n0, 0);
      chk(nerr == e0, "R8", "short pulse gives no fault", nerr - e0, 0);
    end

    // R6 / R7 faults
    filt_len = 0; mult = 2'b10; idle(5);
    begin
      int n0, e0;
      n0 = npulse; e0 = nerr;
      in_a = 1; in_b = 1; idle(10);
      chk(nerr - e0 == 1, "R6", "simultaneous edges fault once", nerr - e0, 1);
      chk(npulse == n0, "R6", "no count on fault", npulse - n0, 0);
      chk(err_flag == 1, "R7", "flag set", err_flag, 1);
      idle(5);
      chk(err_flag == 1, "R7", "flag sticky", err_flag, 1);
      @(negedge clk) err_clr = 1; @(negedge clk) err_clr = 0;
      chk(err_flag == 0, "R7", "flag cleared", err_flag, 0);

      n0 = npulse; e0 = nerr;
      in_a = 0; @(negedge clk); in_b = 0; idle(10);
      chk(npulse - n0 == 1 && nerr - e0 == 1, "R6", "edge one cycle later faults",
          (npulse - n0) * 10 + nerr - e0, 11);
      @(negedge clk) err_clr = 1; @(negedge clk) err_clr = 0;

      n0 = npulse; e0 = nerr;
      in_a = 1; idle(3); in_b = 1; idle(10);
      chk(npulse - n0 == 2 && nerr == e0, "R6", "edges outside window",
          (npulse - n0) * 10 + nerr - e0, 20);
      chk(err_flag == 0, "R7", "flag stays clear", err_flag, 0);

      in_a = 0; in_b = 0;
      idle(3); err_clr = 1; @(negedge clk) err_clr = 0;
      chk(err_flag == 1, "R7", "fault beats clear", err_flag, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule